// File: doc/BRIEF.md
# Display RAM Command/Data Write Port

This block sits behind a serial byte receiver that drives a small grey-scale panel. Each received byte arrives with a valid strobe and a data/command select level. A data byte goes straight into a 4-bit-per-pixel display RAM, two pixels per byte, at the current pointer inside a rectangular window. The pointer then moves on by itself and wraps inside that window. A command byte is either an opcode or one of the parameter bytes that follow it. The block knows how many parameters each opcode takes and counts them off.

Only three commands change state: the column window, the row window and the addressing-mode (remap) register. Commands for brightness, timing, grey scale and power are recognised and their parameters are absorbed without effect. An opcode the block does not know raises a one-cycle error pulse. A sticky dirty flag tells the display refresh logic that the RAM has changed.

Top module: `panel_ram_writer`

## Requirements
- R1: A byte with `byte_vld` high and `dc_sel` high (data) makes `ram_we` high in the next cycle, with `ram_wdata` equal to the byte and `ram_addr` = row*64 + column of the pointer before the write. No other cycle asserts `ram_we`; in particular a command byte never does.
- R2: After reset the pointer is at column 0, row 0, the column window is 0..63, the row window is 0..79, the remap register is 0 (horizontal order), and `ram_we`, `cmd_err` and `dirty` are low.
- R3: With remap bit 2 clear, each data write increments the column. A column that would exceed the column end reloads the column start and increments the row. After that, a row above the row end reloads the row start.
- R4: With remap bit 2 set (value 0x04), each data write increments the row. A row that would exceed the row end reloads the row start and increments the column. After that, a column above the column end reloads the column start.
- R5: Opcode 0x15 followed by two parameter bytes sets the column pointer and the column start to the first parameter mod 64, and the column end to the second parameter mod 64.
- R6: Opcode 0x75 followed by two parameter bytes sets the row pointer and the row start to the first parameter mod 80, and the row end to the second parameter mod 80.
- R7: Opcode 0xA0 stores its single parameter as the remap register. Opcodes 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF consume one parameter, and 0xB8 consumes eight. Opcodes 0x84-0x86, 0xA4-0xA7, 0xAE, 0xAF, 0xE3 and 0xFF take none. None of these changes the pointer or the windows, and their parameter bytes are never decoded as opcodes.
- R8: A command byte in opcode position that is not listed in R5-R7 makes `cmd_err` high for exactly the next cycle, and the next command byte is decoded as an opcode. Listed opcodes never raise `cmd_err`.
- R9: In any cycle where `dc_sel` is high, the parameter count is cleared, so the next command byte is decoded as an opcode.
- R10: `dirty` goes high in the cycle `ram_we` first asserts, and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | A received byte is present this cycle |
| byte_in | input | 8 | Received byte |
| dc_sel | input | 1 | 1 = data byte, 0 = command byte |
| ram_we | output | 1 | Display RAM write enable |
| ram_addr | output | 13 | Display RAM byte address |
| ram_wdata | output | 8 | Display RAM write data (two pixels) |
| cmd_err | output | 1 | One-cycle pulse on an unknown opcode |
| dirty | output | 1 | RAM has been written since reset |

## Verification
Directed runs cover the reset window, a column window whose start lies beyond its end, row parameters that need reduction mod 80, and vertical order wrapping both axes. Together these separate the column-first from the row-first stepping and show that the modulo reductions are correct. Other directed runs send a long parameter opcode whose parameters look like window opcodes, a select-line flip in the middle of a parameter list, and an unknown opcode. These show whether the parser counts parameters per opcode, or mistakes parameters for opcodes. The long constrained-random mix of data, opcodes, parameters and idle cycles, with the select level toggling, then checks every output cycle against a bench model.

// File: rtl/panel_wr_pkg.sv
package panel_wr_pkg;

    // Width of the parameter counter; the longest opcode takes 8 parameters.
    localparam int PCNT_W = 4;

    // What a decoded opcode does once its parameters are collected.
    typedef enum logic [2:0] {
        OPK_NONE   = 3'd0,  // known opcode, parameters ignored
        OPK_COLWIN = 3'd1,  // column window
        OPK_ROWWIN = 3'd2,  // row window
        OPK_MODE   = 3'd3,  // addressing mode register
        OPK_BAD    = 3'd4   // not a known opcode
    } op_kind_e;

endpackage

// File: rtl/panel_op_decode.sv
module panel_op_decode
    import panel_wr_pkg::*;
(
    input  logic [7:0]        opcode,
    output op_kind_e          kind,
    output logic [PCNT_W-1:0] nparam
);
    always_comb begin
        kind   = OPK_NONE;
        nparam = '0;
        unique case (opcode)
            8'h15: begin kind = OPK_COLWIN; nparam = PCNT_W'(2); end
            8'h75: begin kind = OPK_ROWWIN; nparam = PCNT_W'(2); end
            8'hA0: begin kind = OPK_MODE;   nparam = PCNT_W'(1); end
            8'h81, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
            8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF:
                nparam = PCNT_W'(1);
            8'hB8:
                nparam = PCNT_W'(8);
            8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6, 8'hA7,
            8'hAE, 8'hAF, 8'hE3, 8'hFF:
                nparam = '0;
            default: kind = OPK_BAD;
        endcase
    end
endmodule

// File: rtl/panel_win_step.sv
module panel_win_step #(
    parameter int CW = 6,
    parameter int RW = 7
) (
    input  logic          vertical,
    input  logic [CW-1:0] col,
    input  logic [RW-1:0] row,
    input  logic [CW-1:0] col_first,
    input  logic [CW-1:0] col_last,
    input  logic [RW-1:0] row_first,
    input  logic [RW-1:0] row_last,
    output logic [CW-1:0] col_next,
    output logic [RW-1:0] row_next
);
    logic [CW:0] c_t;
    logic [RW:0] r_t;

    always_comb begin
        c_t = {1'b0, col};
        r_t = {1'b0, row};
        if (vertical) begin
            r_t = r_t + 1'b1;
            if (r_t > {1'b0, row_last}) begin
                r_t = {1'b0, row_first};
                c_t = c_t + 1'b1;
            end
            if (c_t > {1'b0, col_last}) begin
                c_t = {1'b0, col_first};
            end
        end else begin
            c_t = c_t + 1'b1;
            if (c_t > {1'b0, col_last}) begin
                c_t = {1'b0, col_first};
                r_t = r_t + 1'b1;
            end
            if (r_t > {1'b0, row_last}) begin
                r_t = {1'b0, row_first};
            end
        end
        col_next = c_t[CW-1:0];
        row_next = r_t[RW-1:0];
    end
endmodule

// File: rtl/panel_ram_writer.sv
module panel_ram_writer
    import panel_wr_pkg::*;
#(
    parameter int COLS     = 64,
    parameter int ROWS     = 80,
    parameter int VERT_BIT = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                byte_vld,
    input  logic [7:0]                          byte_in,
    input  logic                                dc_sel,
    output logic                                ram_we,
    output logic [$clog2(COLS*ROWS)-1:0]        ram_addr,
    output logic [7:0]                          ram_wdata,
    output logic                                cmd_err,
    output logic                                dirty
);
    localparam int CW       = $clog2(COLS);
    localparam int RW       = $clog2(ROWS);
    localparam int AW       = $clog2(COLS*ROWS);
    localparam int COL_ITER = 256 / COLS + 1;
    localparam int ROW_ITER = 256 / ROWS + 1;

    typedef struct packed {
        logic [CW-1:0]     col;
        logic [RW-1:0]     row;
        logic [CW-1:0]     col_first;
        logic [CW-1:0]     col_last;
        logic [RW-1:0]     row_first;
        logic [RW-1:0]     row_last;
        logic [7:0]        mode;
        op_kind_e          kind;
        logic [PCNT_W-1:0] pend;
        logic [7:0]        first_par;
        logic              we;
        logic [AW-1:0]     addr;
        logic [7:0]        wdata;
        logic              err;
        logic              dirty;
    } wr_state_t;

    wr_state_t st_d, st_q;

    op_kind_e          dec_kind;
    logic [PCNT_W-1:0] dec_n;
    logic [CW-1:0]     step_col;
    logic [RW-1:0]     step_row;

    function automatic logic [CW-1:0] col_wrap(input logic [7:0] v);
        int t;
        t = int'(v);
        for (int i = 0; i < COL_ITER; i++) begin
            if (t >= COLS) t = t - COLS;
        end
        return CW'(t);
    endfunction

    function automatic logic [RW-1:0] row_wrap(input logic [7:0] v);
        int t;
        t = int'(v);
        for (int i = 0; i < ROW_ITER; i++) begin
            if (t >= ROWS) t = t - ROWS;
        end
        return RW'(t);
    endfunction

    panel_op_decode u_dec (
        .opcode (byte_in),
        .kind   (dec_kind),
        .nparam (dec_n)
    );

    panel_win_step #(.CW(CW), .RW(RW)) u_step (
        .vertical  (st_q.mode[VERT_BIT]),
        .col       (st_q.col),
        .row       (st_q.row),
        .col_first (st_q.col_first),
        .col_last  (st_q.col_last),
        .row_first (st_q.row_first),
        .row_last  (st_q.row_last),
        .col_next  (step_col),
        .row_next  (step_row)
    );

    always_comb begin
        st_d     = st_q;
        st_d.we  = 1'b0;
        st_d.err = 1'b0;
        if (dc_sel) begin
            st_d.pend = '0;
        end
        if (byte_vld) begin
            if (dc_sel) begin
                st_d.we    = 1'b1;
                st_d.addr  = AW'(st_q.row) * AW'(COLS) + AW'(st_q.col);
                st_d.wdata = byte_in;
                st_d.col   = step_col;
                st_d.row   = step_row;
                st_d.dirty = 1'b1;
            end else if (st_q.pend == '0) begin
                if (dec_kind == OPK_BAD) begin
                    st_d.err = 1'b1;
                end else begin
                    st_d.kind = dec_kind;
                    st_d.pend = dec_n;
                end
            end else begin
                st_d.pend = st_q.pend - 1'b1;
                if (st_q.pend == PCNT_W'(1)) begin
                    unique case (st_q.kind)
                        OPK_COLWIN: begin
                            st_d.col       = col_wrap(st_q.first_par);
                            st_d.col_first = col_wrap(st_q.first_par);
                            st_d.col_last  = col_wrap(byte_in);
                        end
                        OPK_ROWWIN: begin
                            st_d.row       = row_wrap(st_q.first_par);
                            st_d.row_first = row_wrap(st_q.first_par);
                            st_d.row_last  = row_wrap(byte_in);
                        end
                        OPK_MODE: st_d.mode = byte_in;
                        default: ;
                    endcase
                end else begin
                    st_d.first_par = byte_in;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.col_last  <= CW'(COLS - 1);
            st_q.row_last  <= RW'(ROWS - 1);
            st_q.kind      <= OPK_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_we    = st_q.we;
    assign ram_addr  = st_q.addr;
    assign ram_wdata = st_q.wdata;
    assign cmd_err   = st_q.err;
    assign dirty     = st_q.dirty;

endmodule

module panel_ram_writer_chk #(
    parameter int AW    = 13,
    parameter int DEPTH = 5120
) (
    input logic          clk,
    input logic          rst_n,
    input logic          byte_vld,
    input logic [7:0]    byte_in,
    input logic          dc_sel,
    input logic          ram_we,
    input logic [AW-1:0] ram_addr,
    input logic [7:0]    ram_wdata,
    input logic          cmd_err,
    input logic          dirty
);
    AST_WRITE_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && dc_sel) |=> (ram_we && ram_wdata == $past(byte_in))); // R1
    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_vld && dc_sel) |=> !ram_we); // R1
    AST_ADDR_IN_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (int'(ram_addr) < DEPTH)); // R3
    AST_ERR_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_vld && !dc_sel) |=> !cmd_err); // R8
    AST_DIRTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        dirty |=> dirty); // R10
    AST_DIRTY_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> dirty); // R10
endmodule

bind panel_ram_writer panel_ram_writer_chk #(.AW(AW), .DEPTH(COLS*ROWS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld  (byte_vld),
    .byte_in   (byte_in),
    .dc_sel    (dc_sel),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .cmd_err   (cmd_err),
    .dirty     (dirty)
);

// File: tb/panel_ram_writer_test.sv
`timescale 1ns/1ps
module panel_ram_writer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = '0;
    logic        dc_sel = 1'b0;
    logic        ram_we;
    logic [12:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        cmd_err;
    logic        dirty;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model of the requirements
    int mcol, mrow, mcs, mce, mrs, mre, mmode, mpend, mkind, mp0;
    int e_we, e_addr, e_data, e_err, e_dirty;
    string e_tag;
    string ctx = "";

    panel_ram_writer uut (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .dc_sel(dc_sel), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .cmd_err(cmd_err), .dirty(dirty)
    );

    always #2 clk = ~clk;

    // parameter count per R5-R8: -1 marks an unknown opcode
    function automatic int par_count(int op);
        case (op)
            'h15, 'h75: return 2;
            'hA0, 'h81, 'hA1, 'hA2, 'hA8, 'hAD,
            'hB1, 'hB2, 'hB3, 'hBC, 'hBE, 'hBF: return 1;
            'hB8: return 8;
            'h84, 'h85, 'h86, 'hA4, 'hA5, 'hA6, 'hA7,
            'hAE, 'hAF, 'hE3, 'hFF: return 0;
            default: return -1;
        endcase
    endfunction

    function automatic int op_kind(int op);
        if (op == 'h15) return 1;
        if (op == 'h75) return 2;
        if (op == 'hA0) return 3;
        return 0;
    endfunction

    task automatic model_reset();
        mcol = 0; mrow = 0; mcs = 0; mce = 63; mrs = 0; mre = 79;
        mmode = 0; mpend = 0; mkind = 0; mp0 = 0;
        e_we = 0; e_addr = 0; e_data = 0; e_err = 0; e_dirty = 0; e_tag = "R2";
    endtask

    task automatic model_advance();
        if ((mmode & 4) != 0) begin           // R4 row-first order
            mrow++;
            if (mrow > mre) begin mrow = mrs; mcol++; end
            if (mcol > mce) mcol = mcs;
        end else begin                        // R3 column-first order
            mcol++;
            if (mcol > mce) begin mcol = mcs; mrow++; end
            if (mrow > mre) mrow = mrs;
        end
    endtask

    task automatic model_apply(bit v, bit dc, int b);
        e_we = 0; e_err = 0;
        if (dc) mpend = 0;
        if (v) begin
            if (dc) begin
                e_we = 1; e_addr = mrow * 64 + mcol; e_data = b; e_dirty = 1;
                e_tag = (ctx != "") ? ctx : (((mmode & 4) != 0) ? "R4" : "R3");
                model_advance();
            end else if (mpend == 0) begin
                if (par_count(b) < 0) e_err = 1;
                else begin mpend = par_count(b); mkind = op_kind(b); end
            end else begin
                if (mpend == 1) begin
                    if (mkind == 1) begin mcol = mp0 % 64; mcs = mcol; mce = b % 64; end
                    if (mkind == 2) begin mrow = mp0 % 80; mrs = mrow; mre = b % 80; end
                    if (mkind == 3) mmode = b;
                end else mp0 = b;
                mpend--;
            end
        end
    endtask

    task automatic chk(string tag, int got, int exp, string what);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R1", int'(ram_we), e_we, "ram_we");
        if (e_we == 1) begin
            chk("R1", int'(ram_wdata), e_data, "ram_wdata");
            chk(e_tag, int'(ram_addr), e_addr, "ram_addr");
        end
        chk("R8", int'(cmd_err), e_err, "cmd_err");
        chk("R10", int'(dirty), e_dirty, "dirty");
    endtask

    task automatic step(bit v, bit dc, int b);
        @(negedge clk);
        compare();
        byte_vld = v; dc_sel = dc; byte_in = 8'(b);
        model_apply(v, dc, b);
    endtask

    task automatic cmd(int b);  step(1'b1, 1'b0, b); endtask
    task automatic dat(int b);  step(1'b1, 1'b1, b); endtask
    task automatic idle(bit dc); step(1'b0, dc, 0); endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int seed;
        int r;
        seed = 7;
        r = $urandom(seed);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2: reset state of outputs
        chk("R2", int'(ram_we), 0, "ram_we at reset");
        chk("R2", int'(cmd_err), 0, "cmd_err at reset");
        chk("R2", int'(dirty), 0, "dirty at reset");
        rst_n = 1'b1;

        // R2: default window, 64 writes then wrap onto row 1, 80 rows wrap to 0
        ctx = "R2";
        for (int i = 0; i < 64 * 80 + 3; i++) dat(i & 255);
        idle(1'b0);
        ctx = "";

        // R5: column start beyond end, parameters reduced mod 64
        ctx = "R5";
        cmd('h15); cmd(62); cmd(65);
        for (int i = 0; i < 6; i++) dat(i);
        ctx = "";

        // R6: row parameters reduced mod 80
        ctx = "R6";
        cmd('h75); cmd(200); cmd(79);
        cmd('h15); cmd(0); cmd(2);
        for (int i = 0; i < 5; i++) dat(i);
        ctx = "";

        // R4: vertical order, small window wrapping both axes
        cmd('hA0); cmd('h04);
        cmd('h15); cmd(3); cmd(4);
        cmd('h75); cmd(77); cmd(79);
        for (int i = 0; i < 8; i++) dat(i);
        cmd('hA0); cmd('h00);
        for (int i = 0; i < 4; i++) dat(i);

        // R7: parameters that look like opcodes are absorbed
        ctx = "R7";
        cmd('hB8); cmd('h15); cmd(9); cmd(9); cmd('h75); cmd(1); cmd(1); cmd('hA0); cmd(4);
        cmd('h81); cmd('h15); cmd('hE3); cmd('hFF); cmd('hAE);
        dat('h5A); dat('hA5);
        ctx = "";

        // R8: unknown opcode pulses the error, next byte is an opcode again
        cmd('h00); idle(1'b0); cmd('h42); cmd('h15); cmd(10); cmd(20);
        dat(1);

        // R9: select level high aborts a half-received parameter list
        ctx = "R9";
        cmd('h75); cmd(5); idle(1'b1); idle(1'b0);
        cmd('h15); cmd(30); cmd(31);
        dat(2); dat(3); dat(4);
        cmd('hB8); cmd(1); dat(5); cmd('hA0); cmd(0); dat(6);
        ctx = "";

        // constrained random mix
        for (int n = 0; n < 6000; n++) begin
            int k;
            int b;
            k = $urandom_range(0, 99);
            if (k < 40) dat($urandom_range(0, 255));
            else if (k < 55) begin
                case ($urandom_range(0, 5))
                    0: b = 'h15;
                    1: b = 'h75;
                    2: b = 'hA0;
                    3: b = 'hB8;
                    4: b = 'hFF;
                    default: b = $urandom_range(0, 255);
                endcase
                cmd(b);
            end else if (k < 80) begin
                if ($urandom_range(0, 3) == 0) cmd($urandom_range(0, 1) != 0 ? 4 : 0);
                else cmd($urandom_range(0, 255));
            end else idle($urandom_range(0, 5) == 0);
        end
        idle(1'b0);
        @(negedge clk);
        compare();
        finish_run();
    end
endmodule